// File: doc/BRIEF.md
# HDLC Bus Access Collision Controller

This block lets one HDLC transmitter share an open-drain serial line with other nodes, where a node pulling the line low always overrides a node that releases it. The host writes a whole frame into a local byte buffer. The block then watches the line through a sense input and waits for a quiet period. When the line has been quiet long enough, it sends the frame one bit per transmit clock: an opening flag, the data bytes with zero insertion, and a closing flag.

While it sends, every bit it drives is compared with the level seen on the line in the same bit period. If the block released the line (a 1) but the line reads low, another node has won. The block lets go of the line, reports the loss, and goes back to waiting. It then sends the whole frame again from the opening flag, with no help from the host. The host sees a done pulse only when the closing flag has gone out without any collision.

Top module: `hdlc_bus_arb`

## Requirements
- R1: During and right after reset, `txd_rel` is 1, `load_ready` is 1, `frame_done` and `lost` are 0, and `lost_count` is 0.
- R2: While no frame is held, `load_ready` is 1 and each cycle with `load_valid` high stores one byte. The byte with `load_last` high, or the DEPTH-th byte, ends loading and makes the frame pending. `load_ready` then stays 0 until `frame_done`.
- R3: A pending frame waits until `bus_sense` has been sampled 1 on IDLE_ONES (8) consecutive rising edges. Any 0 sample restarts the count. The first frame bit is driven from the same edge that samples the eighth 1, so it appears 8 edges after loading ends when the line stays high.
- R4: The bit sequence on `txd_rel` is: the flag 0x7E, then each byte in load order least significant bit first, then the flag 0x7E. The bits of each flag go out as 0,1,1,1,1,1,1,0.
- R5: In the data part, a 0 bit is inserted after every run of five 1 data bits, and the run is counted across byte boundaries. This also applies after the last data bit, before the closing flag. Flags are never stuffed.
- R6: Each driven bit is compared with `bus_sense` on the rising edge that ends that bit. A match, or a driven 0, lets the transmission continue unchanged.
- R7: If the block drove 1 and sampled 0, then on that same edge `lost` pulses for one cycle and `txd_rel` returns to 1. The frame stays pending, with the quiet-period count restarted from zero.
- R8: After a loss, the whole frame is sent again from the opening flag after a fresh run of 8 ones, without any host action.
- R9: `lost_count` rises by one on each loss, saturating at its maximum, and does not change otherwise.
- R10: `frame_done` pulses for one cycle on the edge that samples the last closing-flag bit without a loss. From that edge on, `txd_rel` is 1 and `load_ready` is 1.
- R11: `txd_rel` is an open-drain enable: 1 releases the line and 0 pulls it low. It is 1 whenever the block is not sending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit bit clock; all sampling is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | A frame byte is offered on `load_data` |
| load_data | input | 8 | Frame byte |
| load_last | input | 1 | Marks the final byte of the frame |
| load_ready | output | 1 | Buffer is free and accepts bytes |
| bus_sense | input | 1 | Level of the shared line (wired-AND of all nodes) |
| txd_rel | output | 1 | 1 releases the line, 0 pulls it low |
| frame_done | output | 1 | One-cycle pulse when a frame completed without a loss |
| lost | output | 1 | One-cycle pulse when a collision was lost |
| lost_count | output | CNT_W | Saturating count of lost collisions |

## Verification
If loading ends on edge E, or a loss is flagged on edge E, and the line then stays high, the first flag bit shows on `txd_rel` right after edge E+8. Bit j of the expected sequence then holds from edge E+8+j. A loss caused by bit j shows up as `lost` and a released line right after edge E+9+j, and `frame_done` rises right after the edge that follows the last flag bit. The bench counts edges from the end of loading, samples every output at the falling edge in the middle of each bit, and moves its start index forward by 8 edges after each injected quiet-period break or loss. Contending zeros from a model rival node are applied from a falling edge, so the block sees them on the next rising edge.

// File: rtl/hdlc_bus_arb.sv
module hdlc_bus_arb #(
  parameter int DEPTH     = 16,
  parameter int IDLE_ONES = 8,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_valid,
  input  logic [7:0]       load_data,
  input  logic             load_last,
  output logic             load_ready,
  input  logic             bus_sense,
  output logic             txd_rel,
  output logic             frame_done,
  output logic             lost,
  output logic [CNT_W-1:0] lost_count
);

  localparam int AW = $clog2(DEPTH);
  localparam int OW = $clog2(IDLE_ONES + 1);
  localparam logic [7:0] FLAG = 8'h7E;

  localparam logic [1:0] PH_OPEN  = 2'd0;
  localparam logic [1:0] PH_DATA  = 2'd1;
  localparam logic [1:0] PH_CLOSE = 2'd2;
  localparam logic [1:0] PH_END   = 2'd3;

  typedef enum logic [1:0] {S_LOAD, S_WAIT, S_SEND} st_t;

  st_t           st;
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW:0]   len;
  logic [OW-1:0] idle_cnt;

  logic [1:0]    ph;
  logic [2:0]    bit_i;
  logic [AW-1:0] byte_i;
  logic [2:0]    ones;
  logic          data_end;

  logic stuff, cur_data, nxt_bit, last_byte;
  logic load_end, go, loss, rewind, step;

  assign load_ready = (st == S_LOAD);
  assign stuff      = (ph == PH_DATA) && (ones == 3'd5);
  assign cur_data   = mem[byte_i][bit_i];
  assign nxt_bit    = (ph == PH_DATA) ? (!stuff && cur_data) : FLAG[bit_i];
  assign last_byte  = ({1'b0, byte_i} + 1'b1) == len;

  assign load_end = (st == S_LOAD) && load_valid &&
                    (load_last || wr_ptr == AW'(DEPTH - 1));
  assign go       = (st == S_WAIT) && bus_sense && (idle_cnt == OW'(IDLE_ONES - 1));
  assign loss     = (st == S_SEND) && txd_rel && !bus_sense;
  assign rewind   = load_end || loss;
  assign step     = go || ((st == S_SEND) && !loss && ph != PH_END);

  always_ff @(posedge clk) begin
    if (st == S_LOAD && load_valid) mem[wr_ptr] <= load_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_LOAD;
      wr_ptr     <= '0;
      len        <= '0;
      idle_cnt   <= '0;
      txd_rel    <= 1'b1;
      frame_done <= 1'b0;
      lost       <= 1'b0;
      lost_count <= '0;
    end else begin
      frame_done <= 1'b0;
      lost       <= 1'b0;
      case (st)
        S_LOAD: begin
          if (load_valid) begin
            if (load_end) begin
              len      <= {1'b0, wr_ptr} + 1'b1;
              wr_ptr   <= '0;
              idle_cnt <= '0;
              st       <= S_WAIT;
            end else begin
              wr_ptr <= wr_ptr + 1'b1;
            end
          end
        end
        S_WAIT: begin
          if (go) begin
            st      <= S_SEND;
            txd_rel <= nxt_bit;
          end else begin
            idle_cnt <= bus_sense ? idle_cnt + 1'b1 : '0;
          end
        end
        S_SEND: begin
          if (loss) begin
            st       <= S_WAIT;
            txd_rel  <= 1'b1;
            idle_cnt <= '0;
            lost     <= 1'b1;
            if (lost_count != '1) lost_count <= lost_count + 1'b1;
          end else if (ph == PH_END) begin
            st         <= S_LOAD;
            txd_rel    <= 1'b1;
            frame_done <= 1'b1;
          end else begin
            txd_rel <= nxt_bit;
          end
        end
        default: st <= S_LOAD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_OPEN;
      bit_i    <= '0;
      byte_i   <= '0;
      ones     <= '0;
      data_end <= 1'b0;
    end else if (rewind) begin
      ph       <= PH_OPEN;
      bit_i    <= '0;
      byte_i   <= '0;
      ones     <= '0;
      data_end <= 1'b0;
    end else if (step) begin
      case (ph)
        PH_OPEN: begin
          bit_i <= bit_i + 1'b1;
          if (bit_i == 3'd7) ph <= PH_DATA;
        end
        PH_DATA: begin
          if (stuff) begin
            ones <= '0;
            if (data_end) ph <= PH_CLOSE;
          end else begin
            ones  <= cur_data ? ones + 1'b1 : 3'd0;
            bit_i <= bit_i + 1'b1;
            if (bit_i == 3'd7) begin
              byte_i <= byte_i + 1'b1;
              if (last_byte) begin
                if (cur_data && ones == 3'd4) data_end <= 1'b1;
                else ph <= PH_CLOSE;
              end
            end
          end
        end
        PH_CLOSE: begin
          bit_i <= bit_i + 1'b1;
          if (bit_i == 3'd7) ph <= PH_END;
        end
        default: ph <= PH_END;
      endcase
    end
  end

endmodule

module hdlc_bus_arb_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_ready,
  input logic             bus_sense,
  input logic             txd_rel,
  input logic             frame_done,
  input logic             lost,
  input logic [CNT_W-1:0] lost_count
);

  p_ready_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_ready |-> txd_rel);

  p_loss_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> ($past(txd_rel) && !$past(bus_sense)));

  p_loss_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> (txd_rel && !load_ready));

  p_count_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lost && $past(lost_count) != '1) |-> lost_count == $past(lost_count) + CNT_W'(1));

  p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lost |-> lost_count == $past(lost_count));

  p_done_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (load_ready && txd_rel && !lost));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

endmodule

bind hdlc_bus_arb hdlc_bus_arb_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .load_ready(load_ready), .bus_sense(bus_sense),
  .txd_rel(txd_rel), .frame_done(frame_done), .lost(lost), .lost_count(lost_count)
);

// File: tb/hdlc_bus_arb_tb_top.sv
`timescale 1ns/1ps
module hdlc_bus_arb_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_valid = 1'b0;
  logic [7:0] load_data = '0;
  logic       load_last = 1'b0;
  logic       load_ready;
  logic       bus_sense;
  logic       txd_rel;
  logic       frame_done;
  logic       lost;
  logic [7:0] lost_count;
  logic       rival_rel = 1'b1;

  int total = 0;
  int fails = 0;
  int exp_losses = 0;
  logic [7:0] fb [16];
  bit   exp_bits [256];
  int   exp_len;

  always #5 clk = ~clk;
  assign bus_sense = txd_rel & rival_rel;

  hdlc_bus_arb dut_i (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_data(load_data),
    .load_last(load_last), .load_ready(load_ready), .bus_sense(bus_sense),
    .txd_rel(txd_rel), .frame_done(frame_done), .lost(lost), .lost_count(lost_count)
  );

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic void push(bit b);
    exp_bits[exp_len] = b;
    exp_len++;
  endfunction

  // R4 flag/data order, R5 zero insertion after five data ones
  function automatic void build_seq(int n);
    int run = 0;
    exp_len = 0;
    for (int i = 0; i < 8; i++) push(i != 0 && i != 7);
    for (int b = 0; b < n; b++)
      for (int i = 0; i < 8; i++) begin
        push(fb[b][i]);
        run = fb[b][i] ? run + 1 : 0;
        if (run == 5) begin push(1'b0); run = 0; end
      end
    for (int i = 0; i < 8; i++) push(i != 0 && i != 7);
  endfunction

  task automatic run_frame(int n, bit use_last, int gap_k, int coll_j, string tag);
    int base, k, lost_before, bad_at;
    bit seq_ok, pre_ok, fin, coll_pending;
    lost_before = exp_losses;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      load_valid = 1'b1;
      load_data  = fb[i];
      load_last  = use_last && (i == n - 1);
    end
    @(negedge clk);
    load_valid = 1'b0;
    load_last  = 1'b0;
    chk(!load_ready, "R2 ready low while pending", load_ready, 0);
    base = 8; k = 0; seq_ok = 1; pre_ok = 1; fin = 0; bad_at = -1;
    coll_pending = (coll_j >= 0);
    while (!fin && k < 3000) begin
      @(negedge clk);
      k++;
      if (gap_k >= 0 && k == gap_k + 1) begin
        rival_rel = 1'b1;
        base = k + 8;
      end
      if (coll_pending && k == base + coll_j + 1) begin
        rival_rel = 1'b1;
        coll_pending = 0;
        if (exp_bits[coll_j]) begin
          exp_losses++;
          chk(lost == 1'b1, "R7 lost pulse", lost, 1);
          chk(txd_rel == 1'b1, "R7 line released", txd_rel, 1);
          chk(int'(lost_count) == lost_before + 1, "R9 lost_count", lost_count, lost_before + 1);
          base = k + 8;
        end else begin
          chk(lost == 1'b0, "R6 zero bit keeps sending", lost, 0);
        end
      end
      if (k < base) begin
        if (!txd_rel) pre_ok = 0;
      end else if (k < base + exp_len) begin
        if (txd_rel != exp_bits[k - base] && seq_ok) begin seq_ok = 0; bad_at = k - base; end
      end else begin
        chk(frame_done == 1'b1, "R10 done pulse", frame_done, 1);
        chk(load_ready && txd_rel, "R10 idle after done", {load_ready, txd_rel}, 3);
        fin = 1;
      end
      if (gap_k >= 0 && k == gap_k) rival_rel = 1'b0;
      if (coll_pending && k == base + coll_j) rival_rel = 1'b0;
    end
    rival_rel = 1'b1;
    chk(fin, "watchdog frame end", fin, 1);
    chk(pre_ok, "R3 line released until 8 idle ones", pre_ok, 1);
    chk(seq_ok, tag, bad_at, -1);
    if (coll_j >= 0 && exp_bits[coll_j])
      chk(seq_ok, "R8 full resend after loss", bad_at, -1);
    @(negedge clk);
    chk(!frame_done, "R10 done is one cycle", frame_done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n, cj, gk;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(txd_rel && load_ready && !frame_done && !lost && lost_count == 0,
        "R1 reset state", {txd_rel, load_ready, frame_done, lost}, 12);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd_rel && load_ready && lost_count == 0, "R1 after reset", {txd_rel, load_ready}, 3);

    fb[0] = 8'h5A; fb[1] = 8'h3C; build_seq(2);
    run_frame(2, 1, -1, -1, "R4 plain frame");
    fb[0] = 8'hFF; fb[1] = 8'hFF; build_seq(2);
    run_frame(2, 1, -1, -1, "R5 stuffing across bytes");
    fb[0] = 8'hF8; build_seq(1);
    run_frame(1, 1, -1, -1, "R5 stuff before closing flag");
    fb[0] = 8'h7E; build_seq(1);
    run_frame(1, 1, -1, -1, "R5 data flag pattern");
    fb[0] = 8'h11; build_seq(1);
    run_frame(1, 1, 5, -1, "R3 idle count restart");
    fb[0] = 8'hA5; fb[1] = 8'h0F; build_seq(2);
    run_frame(2, 1, -1, 1, "R7 loss in opening flag");
    run_frame(2, 1, -1, 0, "R6 contention on zero bit");
    run_frame(2, 1, -1, exp_len - 2, "R8 loss in closing flag");
    for (int i = 0; i < 16; i++) fb[i] = 8'(i * 17);
    build_seq(16);
    run_frame(16, 0, -1, -1, "R2 full buffer ends load");

    for (int t = 0; t < 24; t++) begin
      n = $urandom_range(1, 6);
      for (int i = 0; i < n; i++)
        fb[i] = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom_range(0, 255));
      build_seq(n);
      cj = ($urandom_range(0, 1) == 1) ? $urandom_range(0, exp_len - 1) : -1;
      gk = ($urandom_range(0, 2) == 0) ? $urandom_range(1, 7) : -1;
      run_frame(n, 1, gk, cj, "R4 R5 random frame");
    end
    chk(int'(lost_count) == exp_losses, "R9 total losses", lost_count, exp_losses);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule